// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Window Generator

This block sits between a raster pixel source and a 3x3 image filter. Pixels arrive one at a time in raster order with a qualifier and four markers: first pixel of a line, first pixel of a frame, last pixel of a line and last pixel of a frame. The block keeps the two rows above the current one in on-chip line memories. Each accepted pixel shifts a new three-pixel column into a 3x3 register window. The window therefore slides one column per accepted pixel.

A window-valid flag marks the cycles in which all nine window cells hold pixels of the current frame: the current row is at least the third row of the frame and the current column is at least the third column of the line. The line-end and frame-end markers of the pixel that completed the window travel with it. The line width is a parameter and defaults to 480 pixels. The pixel width is set in the shared package.

Top module: `nbhd3_stream`

## Requirements
- R1: While reset is high and in the first cycle after it, `win_valid`, `win_eol` and `win_eof` are 0.
- R2: A pixel is accepted when `in_valid` is 1. Its row index is counted from 0 at the pixel marked frame-start. Its column index is counted from 0 at the pixel marked line-start. `win_valid` is 1 in the cycle after an accepted pixel exactly when that pixel's row index is at least 2 and its column index is at least 2.
- R3: An accepted pixel with `in_sof` high resets the row index and the column index to 0, whether or not `in_sol` is also high. Rows of an earlier frame, complete or cut short, never make a window of the new frame valid.
- R4: When `win_valid` is 1 for the pixel at row y and column x, cell (r,c), with r and c in 0..2, holds the pixel from row y-2+r and column x-2+c. The cell sits at `win_pix[(3*r+c)*PIX_W +: PIX_W]`. Row r=0 is the oldest row and column c=0 is the leftmost column.
- R5: The output follows each accepted pixel by exactly one clock cycle. A cycle with `in_valid` low gives `win_valid` 0 in the next cycle.
- R6: While `in_valid` is 0, the pixel and marker inputs are ignored. `win_pix` holds its value, and the position counters and line memories keep their contents.
- R7: `win_eol` and `win_eof` equal the `in_eol` and `in_eof` of the accepted pixel from the previous cycle, and they are 0 after a cycle with no accepted pixel.
- R8: Lines of any length from 3 up to `LINE_W` pixels give correct windows, including the last column `LINE_W-1` of a full-width line. The line length may change from one frame to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | PIX_W | Input pixel value |
| in_sol | input | 1 | Pixel is the first of its line |
| in_sof | input | 1 | Pixel is the first of its frame |
| in_eol | input | 1 | Pixel is the last of its line |
| in_eof | input | 1 | Pixel is the last of its frame |
| win_valid | output | 1 | All nine window cells hold pixels of the current frame |
| win_pix | output | 9*PIX_W | 3x3 window, cell (r,c) at bits (3r+c)*PIX_W |
| win_eol | output | 1 | Forwarded line-end marker |
| win_eof | output | 1 | Forwarded frame-end marker |

## Verification
The hardest cases to reach are those where stale data sits in the line memories at the very addresses a new frame reads. This happens after a frame that was cut short after two rows, and after a frame with wider lines. Only an incorrect row or column gate would let that stale data show up as a valid window. The stimulus reaches these cases by sending frames of different heights and line widths back to back through a six-pixel-wide configuration.

Each pixel value is a closed-form function of frame, row and column, so the bench can compute all nine expected cells arithmetically. Idle cycles are placed between pixels, and during them every marker is driven high and the pixel input carries junk. This shows that the markers and pixel input are ignored while `in_valid` is low.

// File: rtl/nbhd_pkg.sv
package nbhd_pkg;
    localparam int PIX_W = 8;
    localparam int WIN_N = 3;
    localparam int HIST_ROWS = WIN_N - 1;

    typedef logic [PIX_W-1:0] pix_t;
    // column of the window: index 0 = current row, index k = k rows above
    typedef pix_t [WIN_N-1:0] column_t;
    // window [row][col], row 0 = oldest, col 0 = leftmost
    typedef logic [WIN_N-1:0][WIN_N-1:0][PIX_W-1:0] win_t;
    typedef logic [1:0] rowcnt_t;

    typedef struct packed {
        logic sol;
        logic sof;
        logic eol;
        logic eof;
    } mark_t;

    // row counter saturating at the first row that may yield windows
    function automatic rowcnt_t row_step(rowcnt_t r);
        return (r >= rowcnt_t'(HIST_ROWS)) ? rowcnt_t'(HIST_ROWS) : r + rowcnt_t'(1);
    endfunction
endpackage

// File: rtl/raster_pos.sv
module raster_pos import nbhd_pkg::*; #(
    parameter int LINE_W = 480,
    localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc,
    input  mark_t         mark,
    output rowcnt_t       row_o,
    output logic [CW-1:0] col_o
);
    localparam logic [CW-1:0] COL_MAX = CW'(LINE_W - 1);

    rowcnt_t       row_q;
    logic [CW-1:0] col_q;

    always_comb begin
        if (mark.sof) begin
            row_o = '0;
            col_o = '0;
        end else if (mark.sol) begin
            row_o = row_step(row_q);
            col_o = '0;
        end else begin
            row_o = row_q;
            col_o = (col_q == COL_MAX) ? col_q : col_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (acc) begin
            row_q <= row_o;
            col_q <= col_o;
        end
    end
endmodule

// File: rtl/line_store.sv
module line_store import nbhd_pkg::*; #(
    parameter int LINE_W = 480,
    localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [CW-1:0] addr,
    input  pix_t          din,
    output column_t       col
);
    assign col[0] = din;

    for (genvar k = 0; k < HIST_ROWS; k++) begin : g_row
        pix_t mem [LINE_W];
        // read of old content and write of the row below share one address
        assign col[k+1] = mem[addr];
        always_ff @(posedge clk) begin
            if (we) mem[addr] <= col[k];
        end
    end
endmodule

// File: rtl/col_shift.sv
module col_shift import nbhd_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift,
    input  column_t newcol,
    output win_t    win
);
    for (genvar r = 0; r < WIN_N; r++) begin : g_r
        for (genvar c = 0; c < WIN_N; c++) begin : g_c
            always_ff @(posedge clk) begin
                if (rst) begin
                    win[r][c] <= '0;
                end else if (shift) begin
                    if (c == WIN_N - 1) win[r][c] <= newcol[WIN_N-1-r];
                    else                win[r][c] <= win[r][c+1];
                end
            end
        end
    end
endmodule

// File: rtl/nbhd3_stream.sv
module nbhd3_stream import nbhd_pkg::*; #(
    parameter int LINE_W = 480,
    localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [PIX_W-1:0]             in_pix,
    input  logic                         in_sol,
    input  logic                         in_sof,
    input  logic                         in_eol,
    input  logic                         in_eof,
    output logic                         win_valid,
    output logic [WIN_N*WIN_N*PIX_W-1:0] win_pix,
    output logic                         win_eol,
    output logic                         win_eof
);
    mark_t         mark;
    rowcnt_t       row_cur;
    logic [CW-1:0] col_cur;
    column_t       col_new;
    win_t          win;
    logic          full;

    assign mark = '{sol: in_sol, sof: in_sof, eol: in_eol, eof: in_eof};

    raster_pos #(.LINE_W(LINE_W)) u_pos (
        .clk   (clk),
        .rst   (rst),
        .acc   (in_valid),
        .mark  (mark),
        .row_o (row_cur),
        .col_o (col_cur)
    );

    line_store #(.LINE_W(LINE_W)) u_lines (
        .clk  (clk),
        .we   (in_valid),
        .addr (col_cur),
        .din  (in_pix),
        .col  (col_new)
    );

    col_shift u_win (
        .clk    (clk),
        .rst    (rst),
        .shift  (in_valid),
        .newcol (col_new),
        .win    (win)
    );

    assign full = (row_cur >= rowcnt_t'(HIST_ROWS)) && (col_cur >= CW'(HIST_ROWS));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid <= 1'b0;
            win_eol   <= 1'b0;
            win_eof   <= 1'b0;
        end else begin
            win_valid <= in_valid && full;
            win_eol   <= in_valid && mark.eol;
            win_eof   <= in_valid && mark.eof;
        end
    end

    assign win_pix = win;
endmodule

// File: rtl/nbhd3_stream_chk.sv
module nbhd3_stream_chk import nbhd_pkg::*; (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic                         in_sol,
    input logic                         in_sof,
    input logic                         in_eol,
    input logic                         in_eof,
    input logic                         win_valid,
    input logic [WIN_N*WIN_N*PIX_W-1:0] win_pix,
    input logic                         win_eol,
    input logic                         win_eof
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !win_valid && !win_eol && !win_eof);

    p_sol_gate_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sol |=> !win_valid);

    p_sof_gate_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sof |=> !win_valid);

    p_idle_no_window_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !win_valid);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(win_pix));

    p_eol_forward_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_eol |=> win_eol);

    p_eof_origin_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_eof) |=> !win_eof);
endmodule

bind nbhd3_stream nbhd3_stream_chk u_chk (.*);

// File: tb/nbhd3_stream_test.sv
module nbhd3_stream_test;
    import nbhd_pkg::*;

    localparam int LW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic in_sol = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
    logic win_valid, win_eol, win_eof;
    logic [9*PIX_W-1:0] win_pix;
    logic [9*PIX_W-1:0] last_win;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nbhd3_stream #(.LINE_W(LW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .in_sol(in_sol), .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
        .win_valid(win_valid), .win_pix(win_pix), .win_eol(win_eol), .win_eof(win_eof)
    );

    function automatic logic [PIX_W-1:0] pv(int f, int y, int x);
        return PIX_W'(f * 37 + y * 11 + x * 3 + 1);
    endfunction

    task automatic check(bit ok, string req, logic [9*PIX_W-1:0] act, logic [9*PIX_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs set at a falling edge; outputs sampled at the next falling edge
    task automatic idle();
        in_valid = 1'b0; in_pix = '1;
        in_sol = 1'b1; in_sof = 1'b1; in_eol = 1'b1; in_eof = 1'b1;
        last_win = win_pix;
        @(negedge clk);
        check(win_valid == 1'b0, "R5 idle valid", 72'(win_valid), 72'(0));
        check(win_eol == 1'b0 && win_eof == 1'b0, "R7 idle markers",
              72'({win_eol, win_eof}), 72'(0));
        check(win_pix == last_win, "R6 idle hold", win_pix, last_win);
    endtask

    task automatic frame(int f, int h, int w, int gap);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                logic [9*PIX_W-1:0] exp;
                bit v;
                if (gap != 0 && ((y * w + x) % gap) == gap - 1) idle();
                in_valid = 1'b1;
                in_pix = pv(f, y, x);
                in_sol = (x == 0);
                in_sof = (x == 0 && y == 0);
                in_eol = (x == w - 1);
                in_eof = (x == w - 1 && y == h - 1);
                @(negedge clk);
                v = (y >= 2 && x >= 2);
                check(win_valid == v, "R2/R3 valid gate", 72'(win_valid), 72'(v));
                check(win_eol == (x == w - 1) && win_eof == (x == w - 1 && y == h - 1),
                      "R7 markers", 72'({win_eol, win_eof}),
                      72'({(x == w - 1), (x == w - 1 && y == h - 1)}));
                if (v) begin
                    for (int r = 0; r < 3; r++)
                        for (int c = 0; c < 3; c++)
                            exp[(3 * r + c) * PIX_W +: PIX_W] = pv(f, y - 2 + r, x - 2 + c);
                    check(win_pix == exp, (x == LW - 1) ? "R8 full width window" : "R4 window",
                          win_pix, exp);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(win_valid == 0 && win_eol == 0 && win_eof == 0, "R1 reset",
              72'({win_valid, win_eol, win_eof}), 72'(0));
        rst = 1'b0;
        @(negedge clk);
        check(win_valid == 0 && win_eol == 0 && win_eof == 0, "R1 after reset",
              72'({win_valid, win_eol, win_eof}), 72'(0));
        frame(0, 5, LW, 3);   // full width with idle gaps and junk markers
        frame(1, 2, LW, 0);   // short frame, never valid
        frame(2, 4, 4, 0);    // narrower lines, stale data in memories (R3, R8)
        frame(3, 3, LW, 5);   // back to full width
        frame(4, 6, 3, 2);    // minimal line width
        idle();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule